// File: doc/BRIEF.md
# Host Control Register Interface

This block is the host-facing register file of a pixel-stream processing engine. A host reaches it through a 2-bit address with separate read and write strobes. The four locations are a write-only abort strobe, a mode register, a table pointer, and an indirect port into a configuration table. The mode register holds the encode/decode select, a two-bit pixel-format code, a decimation enable and a converter-delay select. These settings drive the datapath directly.

Setting the start bit in the mode register launches one image. The block then raises a busy flag and emits a one-cycle start pulse. Busy stays high until the engine reports completion or the host writes the abort location. While busy is high, the settings are frozen. The configuration table is never addressed directly. The host loads the pointer, then streams reads or writes through the table port, and each access advances the pointer by one with wrap-around.

Top module: `host_ctrl_regs`

## Requirements
- R1: After reset, busy, engineStart and engineAbort are 0, all mode outputs are 0, and the pointer reads back as 0.
- R2: A write to address 1 while idle loads encodeSel from data bit 1, pixMode from bits 3:2, decimateEn from bit 4 and convDelaySel from bit 5. The new values are visible on the next cycle.
- R3: A read of address 1 returns busy on bit 7 and pixMode on bits 3:2. It returns encodeSel on bit 1 and 0 on bits 0, 4, 5 and 6.
- R4: A write to address 1 with bit 0 set while idle sets busy on the next cycle. In that same cycle engineStart pulses high for exactly one cycle.
- R5: While busy is 1, a pulse on engineDone clears busy on the next cycle.
- R6: While busy is 1, writes to address 1 are ignored: the mode outputs keep their values and no start pulse appears.
- R7: A write to address 0 clears busy and pulses engineAbort for one cycle, on the next cycle. It leaves the mode outputs, the pointer and the table contents unchanged.
- R8: A write to address 2 loads the pointer. Reads of address 2 return the pointer and do not move it.
- R9: A write to address 3 stores the data in the table entry selected by the pointer. A read of address 3 returns that entry. Either access increments the pointer by one, and the pointer wraps from 255 to 0.
- R10: The pixMode output carries the format code unchanged: 00 is 1:0:0 in and out, 01 is 4:2:2 in and out, 10 is 4:2:2 in and 4:1:1 out, and 11 is 4:1:1 in and out.
- R11: A read of address 0 returns 0.
- R12: If engineDone and a mode write both arrive while busy, busy clears and the mode write is still ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostSel | input | 1 | Host access qualifier |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | 2 | Register location |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, combinational on address |
| engineDone | input | 1 | Engine reports the image is finished |
| engineStart | output | 1 | One-cycle start pulse to the engine |
| engineAbort | output | 1 | One-cycle abort pulse to the engine |
| busy | output | 1 | Image in progress |
| encodeSel | output | 1 | 1 = encode, 0 = decode |
| pixMode | output | 2 | Pixel-format code |
| decimateEn | output | 1 | Decimation enable |
| convDelaySel | output | 1 | Converter delay matching select |

## Verification
The completion report from the engine and a host mode write can land in the same clock edge. The bench provokes this by raising engineDone and writing the mode register with new fields and the start bit in a single cycle while an image is running. The expected result is that busy drops, no start pulse appears, and every mode output keeps the values that were set before the image began. The bench also checks that an abort leaves the pointer and a table entry untouched.

// File: rtl/host_regs_pkg.sv
package host_regs_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    LOC_ABORT = 2'b00,
    LOC_MODE  = 2'b01,
    LOC_PTR   = 2'b10,
    LOC_TABLE = 2'b11
  } hostLoc_e;

  typedef struct packed {
    logic softReset;
    logic modeWr;
    logic ptrWr;
    logic tblWr;
    logic tblStep;
  } ctrlStrobes_t;
endpackage

// File: rtl/hcr_control.sv
module hcr_control
  import host_regs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostSel,
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic [1:0]   hostAddr,
  input  logic [5:0]   modeData,
  input  logic         engineDone,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         engineStart,
  output logic         engineAbort,
  output logic         encodeSel,
  output logic [1:0]   pixMode,
  output logic         decimateEn,
  output logic         convDelaySel,
  output logic [7:0]   modeRead
);
  logic anyAccess;
  logic anyWrite;
  logic launch;
  logic modeAccept;

  assign anyAccess = hostSel && (hostWr || hostRd);
  assign anyWrite  = hostSel && hostWr;

  always_comb begin
    strobes           = '0;
    strobes.softReset = anyWrite && (hostAddr == LOC_ABORT);
    strobes.modeWr    = anyWrite && (hostAddr == LOC_MODE);
    strobes.ptrWr     = anyWrite && (hostAddr == LOC_PTR);
    strobes.tblWr     = anyWrite && (hostAddr == LOC_TABLE);
    strobes.tblStep   = anyAccess && (hostAddr == LOC_TABLE);
  end

  assign modeAccept = strobes.modeWr && !busy;
  assign launch     = modeAccept && modeData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy         <= 1'b0;
      engineStart  <= 1'b0;
      engineAbort  <= 1'b0;
      encodeSel    <= 1'b0;
      pixMode      <= 2'b00;
      decimateEn   <= 1'b0;
      convDelaySel <= 1'b0;
    end else begin
      engineStart <= launch;
      engineAbort <= strobes.softReset;
      if (strobes.softReset) begin
        busy <= 1'b0;
      end else if (busy && engineDone) begin
        busy <= 1'b0;
      end else if (launch) begin
        busy <= 1'b1;
      end
      if (modeAccept) begin
        encodeSel    <= modeData[1];
        pixMode      <= modeData[3:2];
        decimateEn   <= modeData[4];
        convDelaySel <= modeData[5];
      end
    end
  end

  assign modeRead = {busy, 3'b000, pixMode, encodeSel, 1'b0};
endmodule

// File: rtl/hcr_datapath.sv
module hcr_datapath
  import host_regs_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [PTR_W-1:0]  ptrNow,
  output logic [DATA_W-1:0] tblData
);
  localparam int TBL_DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] tblMem [TBL_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrNow <= '0;
    end else if (strobes.ptrWr) begin
      ptrNow <= PTR_W'(wrData);
    end else if (strobes.tblStep) begin
      ptrNow <= ptrNow + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.tblWr) begin
      tblMem[ptrNow] <= wrData;
    end
  end

  assign tblData = tblMem[ptrNow];
endmodule

// File: rtl/host_ctrl_regs.sv
module host_ctrl_regs
  import host_regs_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [1:0] hostAddr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  input  logic       engineDone,
  output logic       engineStart,
  output logic       engineAbort,
  output logic       busy,
  output logic       encodeSel,
  output logic [1:0] pixMode,
  output logic       decimateEn,
  output logic       convDelaySel
);
  ctrlStrobes_t      strobes;
  logic [7:0]        modeRead;
  logic [PTR_W-1:0]  ptrNow;
  logic [DATA_W-1:0] tblData;

  hcr_control uControl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .modeData(hostWdata[5:0]), .engineDone(engineDone),
    .strobes(strobes), .busy(busy), .engineStart(engineStart), .engineAbort(engineAbort),
    .encodeSel(encodeSel), .pixMode(pixMode), .decimateEn(decimateEn),
    .convDelaySel(convDelaySel), .modeRead(modeRead)
  );

  hcr_datapath #(.PTR_W(PTR_W)) uDatapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(hostWdata),
    .ptrNow(ptrNow), .tblData(tblData)
  );

  always_comb begin
    case (hostAddr)
      LOC_MODE:  hostRdata = modeRead;
      LOC_PTR:   hostRdata = 8'(ptrNow);
      LOC_TABLE: hostRdata = tblData;
      default:   hostRdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/hcr_checker.sv
module hcr_checker #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostSel,
  input logic             hostWr,
  input logic             hostRd,
  input logic [1:0]       hostAddr,
  input logic             engineDone,
  input logic             engineStart,
  input logic             engineAbort,
  input logic             busy,
  input logic             encodeSel,
  input logic [1:0]       pixMode,
  input logic             decimateEn,
  input logic             convDelaySel,
  input logic [PTR_W-1:0] ptrNow
);
  assert_start_with_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    engineStart |-> busy);

  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    engineStart |=> !engineStart);

  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && engineDone) |=> !busy);

  assert_frozen_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(pixMode) && $stable(encodeSel) && $stable(decimateEn) && $stable(convDelaySel)));

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    engineAbort |-> !busy);

  assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && (hostWr || hostRd) && hostAddr == 2'b11) |=> (ptrNow == PTR_W'($past(ptrNow) + 1'b1)));

  assert_ptr_read_still_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && hostRd && !hostWr && hostAddr == 2'b10) |=> $stable(ptrNow));
endmodule

bind host_ctrl_regs hcr_checker #(.PTR_W(PTR_W)) uChecker (
  .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
  .hostAddr(hostAddr), .engineDone(engineDone), .engineStart(engineStart),
  .engineAbort(engineAbort), .busy(busy), .encodeSel(encodeSel), .pixMode(pixMode),
  .decimateEn(decimateEn), .convDelaySel(convDelaySel), .ptrNow(ptrNow)
);

// File: tb/sim_host_ctrl_regs.sv
module sim_host_ctrl_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [1:0] hostAddr = 2'b00;
  logic [7:0] hostWdata = 8'h00;
  logic [7:0] hostRdata;
  logic engineDone = 1'b0;
  logic engineStart, engineAbort, busy, encodeSel, decimateEn, convDelaySel;
  logic [1:0] pixMode;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_ctrl_regs u0 (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .engineDone(engineDone), .engineStart(engineStart), .engineAbort(engineAbort),
    .busy(busy), .encodeSel(encodeSel), .pixMode(pixMode), .decimateEn(decimateEn),
    .convDelaySel(convDelaySel)
  );

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic hostWrite(input logic [1:0] addr, input logic [7:0] data);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = addr; hostWdata = data;
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] addr, output logic [7:0] data);
    @(negedge clk);
    hostSel = 1'b1; hostRd = 1'b1; hostAddr = addr;
    #1 data = hostRdata;
    @(negedge clk);
    hostSel = 1'b0; hostRd = 1'b0;
  endtask

  task automatic checkMode(input string req, input logic [5:0] v);
    check(req, {encodeSel, pixMode, decimateEn, convDelaySel},
          {v[1], v[3:2], v[4], v[5]});
  endtask

  function automatic logic [7:0] pattern(input int i);
    return 8'((i * 37 + 5) % 256);
  endfunction

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 start", engineStart, 0);
    check("R1 abort", engineAbort, 0);
    check("R1 mode outputs", {encodeSel, pixMode, decimateEn, convDelaySel}, 0);
    hostRead(2'b10, rd); check("R1 pointer", rd, 0);
    hostRead(2'b00, rd); check("R11 abort location read", rd, 0);

    // R2 R3 R10: every field combination while idle
    for (int v = 0; v < 32; v++) begin
      logic [5:0] m;
      m = 6'(v << 1);
      hostWrite(2'b01, {2'b11, m});
      checkMode("R2 mode fields", m);
      check("R10 pixMode code", pixMode, int'(m[3:2]));
      check("R4 no start without go", engineStart, 0);
      hostRead(2'b01, rd);
      check("R3 mode readback", rd, {4'b0000, m[3:2], m[1], 1'b0});
    end

    // R4 start with fields 0x2D: go, mod=11, csc=1
    hostWrite(2'b01, 8'h2D);
    check("R4 busy set", busy, 1);
    check("R4 start pulse", engineStart, 1);
    @(negedge clk);
    check("R4 start single", engineStart, 0);
    hostRead(2'b01, rd);
    check("R3 busy bit", rd, 8'h8C);

    // R6 ignored while busy
    hostWrite(2'b01, 8'h13);
    checkMode("R6 frozen", 6'h2C);
    check("R6 no start", engineStart, 0);

    // R5 done
    @(negedge clk); engineDone = 1'b1;
    @(negedge clk); engineDone = 1'b0;
    check("R5 busy cleared", busy, 0);

    // R12 collision: done and mode write in the same cycle
    hostWrite(2'b01, 8'h25);
    check("R12 busy before", busy, 1);
    @(negedge clk);
    engineDone = 1'b1; hostSel = 1'b1; hostWr = 1'b1; hostAddr = 2'b01; hostWdata = 8'h1B;
    @(negedge clk);
    engineDone = 1'b0; hostSel = 1'b0; hostWr = 1'b0;
    check("R12 busy cleared", busy, 0);
    check("R12 no start", engineStart, 0);
    checkMode("R12 fields kept", 6'h24);

    // R9 table fill and readback with wrap
    hostWrite(2'b10, 8'h00);
    for (int i = 0; i < 256; i++) hostWrite(2'b11, pattern(i));
    hostRead(2'b10, rd); check("R9 pointer wrapped after writes", rd, 0);
    for (int i = 0; i < 256; i++) begin
      hostRead(2'b11, rd);
      check("R9 table data", rd, pattern(i));
    end
    hostRead(2'b10, rd); check("R9 pointer wrapped after reads", rd, 0);

    // R8 pointer load and stable reads
    hostWrite(2'b10, 8'h80);
    hostRead(2'b10, rd); check("R8 pointer load", rd, 8'h80);
    hostRead(2'b10, rd); check("R8 pointer read no step", rd, 8'h80);
    hostWrite(2'b10, 8'hFF);
    hostRead(2'b11, rd); check("R9 last entry", rd, pattern(255));
    hostRead(2'b10, rd); check("R9 wrap single step", rd, 0);
    hostWrite(2'b10, 8'h80);

    // R7 abort
    hostWrite(2'b01, 8'h17);
    check("R7 busy before abort", busy, 1);
    hostWrite(2'b00, 8'hFF);
    check("R7 busy cleared", busy, 0);
    check("R7 abort pulse", engineAbort, 1);
    @(negedge clk);
    check("R7 abort single", engineAbort, 0);
    checkMode("R7 fields kept", 6'h16);
    hostRead(2'b10, rd); check("R7 pointer kept", rd, 8'h80);
    hostRead(2'b11, rd); check("R7 table kept", rd, pattern(128));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule